// File: doc/BRIEF.md
# Configurable D/T Register Macrocell

This block is one output cell of a programmable logic array. It takes the single sum-of-products result from the array and turns it into a pin value and an output enable. A static configuration sets each of these choices for the cell on its own:

- whether the pin shows the raw combinational result or a stored copy of it;
- whether the storage element behaves as a D or a T flip-flop;
- which clock drives it, and on which edge;
- whether one control term initialises it asynchronously to 1 or to 0;
- where the output enable comes from.

Two feedback taps go back to the interconnect. The core tap always carries the register state. The pin tap carries the value present on the pin side of the output buffer.

The register's clock comes from one of the global clocks or from one of the control product terms. The output enable comes from a control term (true or complemented) or from a constant. A global tri-state input overrides it at any time. Pad electrical behaviour is not modelled. When the cell does not drive the pin, the externally driven level arrives on a separate input and appears on the pin-side feedback. A chip-level active-low reset clears the register at power-up. Configuration is expected to change only while that reset is held.

Top module: `mc_macrocell`

## Requirements
- R1: With cfg_tmode_i=0, the register takes the value of d_i on each active clock edge.
- R2: With cfg_tmode_i=1, the register inverts on an active clock edge when d_i is 1 and keeps its value when d_i is 0.
- R3: cfg_clk_inv_i=0 makes the rising edge of the selected clock source active; cfg_clk_inv_i=1 makes the falling edge active, and edges of the other polarity leave the register unchanged.
- R4: cfg_clk_sel_i values 0 to NUM_GCLK-1 pick gclk_i at that index, and value NUM_GCLK+k picks ct_i[k]; edges on unselected sources have no effect.
- R5: While cfg_init_en_i is 1 and ct_i[cfg_init_sel_i] is 1, the register is forced at once to cfg_init_preset_i (1 = preset, 0 = reset) and clock edges are ignored; when the term falls, the register keeps that value until the next active edge.
- R6: pin_o equals d_i when cfg_out_reg_i=0 and equals the register state when cfg_out_reg_i=1.
- R7: cfg_oe_mode_i selects the enable: 0 gives constant off, 1 constant on, 2 ct_i[cfg_oe_sel_i], 3 the complement of ct_i[cfg_oe_sel_i].
- R8: gts_i=1 forces oe_o to 0 whatever the enable selection.
- R9: fb_core_o always carries the register state, in both output modes.
- R10: fb_pin_o equals pin_o while oe_o is 1 and equals pad_i while oe_o is 0.
- R11: rst_ni=0 clears the register to 0 asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous power-up clear of the register |
| gclk_i | input | NUM_GCLK | Global clocks |
| ct_i | input | NUM_CT | Control product terms from the array |
| d_i | input | 1 | Sum-of-products logic input |
| gts_i | input | 1 | Global tri-state; 1 disables the output |
| pad_i | input | 1 | Externally driven pin level seen when the cell does not drive |
| cfg_tmode_i | input | 1 | 0 = D flip-flop, 1 = T flip-flop |
| cfg_clk_sel_i | input | CSEL_W | Clock source index (global clocks first, then control terms) |
| cfg_clk_inv_i | input | 1 | 0 = rising edge, 1 = falling edge |
| cfg_init_en_i | input | 1 | Enables the asynchronous initialisation term |
| cfg_init_sel_i | input | CT_W | Control term used for initialisation |
| cfg_init_preset_i | input | 1 | 1 = initialise to 1, 0 = initialise to 0 |
| cfg_out_reg_i | input | 1 | 0 = combinational pin value, 1 = registered |
| cfg_oe_mode_i | input | 2 | Output-enable source selector |
| cfg_oe_sel_i | input | CT_W | Control term used as output enable |
| pin_o | output | 1 | Value driven toward the pad |
| oe_o | output | 1 | Output enable toward the pad |
| fb_core_o | output | 1 | Feedback of the register state |
| fb_pin_o | output | 1 | Feedback from the pin side of the buffer |

## Verification
The bench runs several configurations through long pseudo-random sequences of clock, term and data activity. It hunts for a few specific failures. A cell on the wrong edge or the wrong source would update on the wrong transitions of the clock inputs. A T register that loads instead of toggling would copy d_i rather than invert the state. An initialisation term that loses against a coincident clock edge, or is ignored while held, would let the state drift away from the preset or reset level. It also drives the global tri-state and the complemented enable term together, and checks that the pin feedback switches to the external level whenever the enable drops. A design that gated the wrong way would show the driven value there instead.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    OE_OFF    = 2'd0,
    OE_ON     = 2'd1,
    OE_TERM   = 2'd2,
    OE_TERM_N = 2'd3
  } oe_mode_e;
endpackage

// File: rtl/mc_clk_sel.sv
module mc_clk_sel #(
  parameter int NUM_GCLK = 2,
  parameter int NUM_CT   = 8,
  parameter int CSEL_W   = 4
) (
  input  logic [NUM_GCLK-1:0] gclk_i,
  input  logic [NUM_CT-1:0]   ct_i,
  input  logic [CSEL_W-1:0]   sel_i,
  input  logic                inv_i,
  output logic                clk_o
);
  logic raw;

  always_comb begin
    raw = 1'b0;
    for (int k = 0; k < NUM_GCLK; k++)
      if (sel_i == CSEL_W'(k)) raw = gclk_i[k];
    for (int k = 0; k < NUM_CT; k++)
      if (sel_i == CSEL_W'(NUM_GCLK + k)) raw = ct_i[k];
  end

  // falling-edge mode is an inversion in front of a rising-edge register
  assign clk_o = raw ^ inv_i;
endmodule

// File: rtl/mc_reg.sv
module mc_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic init_val_i,
  input  logic tmode_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni or posedge init_i) begin
    if (!rst_ni)      q_o <= 1'b0;
    else if (init_i)  q_o <= init_val_i;
    else if (tmode_i) q_o <= q_o ^ d_i;
    else              q_o <= d_i;
  end
endmodule

// File: rtl/mc_oe_ctl.sv
module mc_oe_ctl
  import mc_pkg::*;
#(
  parameter int NUM_CT = 8,
  parameter int CT_W   = 3
) (
  input  logic [NUM_CT-1:0] ct_i,
  input  logic [1:0]        mode_i,
  input  logic [CT_W-1:0]   sel_i,
  input  logic              gts_i,
  output logic              oe_o
);
  logic term;
  logic oe_raw;

  always_comb begin
    term = 1'b0;
    for (int k = 0; k < NUM_CT; k++)
      if (sel_i == CT_W'(k)) term = ct_i[k];
  end

  always_comb begin
    unique case (oe_mode_e'(mode_i))
      OE_OFF:    oe_raw = 1'b0;
      OE_ON:     oe_raw = 1'b1;
      OE_TERM:   oe_raw = term;
      OE_TERM_N: oe_raw = ~term;
      default:   oe_raw = 1'b0;
    endcase
  end

  assign oe_o = oe_raw & ~gts_i;
endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell #(
  parameter int NUM_GCLK = 2,
  parameter int NUM_CT   = 8,
  localparam int CSEL_W  = $clog2(NUM_GCLK + NUM_CT),
  localparam int CT_W    = (NUM_CT > 1) ? $clog2(NUM_CT) : 1
) (
  input  logic                rst_ni,
  input  logic [NUM_GCLK-1:0] gclk_i,
  input  logic [NUM_CT-1:0]   ct_i,
  input  logic                d_i,
  input  logic                gts_i,
  input  logic                pad_i,
  input  logic                cfg_tmode_i,
  input  logic [CSEL_W-1:0]   cfg_clk_sel_i,
  input  logic                cfg_clk_inv_i,
  input  logic                cfg_init_en_i,
  input  logic [CT_W-1:0]     cfg_init_sel_i,
  input  logic                cfg_init_preset_i,
  input  logic                cfg_out_reg_i,
  input  logic [1:0]          cfg_oe_mode_i,
  input  logic [CT_W-1:0]     cfg_oe_sel_i,
  output logic                pin_o,
  output logic                oe_o,
  output logic                fb_core_o,
  output logic                fb_pin_o
);
  logic clk_eff;
  logic init_term;
  logic init_act;
  logic q;

  mc_clk_sel #(
    .NUM_GCLK(NUM_GCLK), .NUM_CT(NUM_CT), .CSEL_W(CSEL_W)
  ) u_clk_sel (
    .gclk_i(gclk_i), .ct_i(ct_i), .sel_i(cfg_clk_sel_i),
    .inv_i(cfg_clk_inv_i), .clk_o(clk_eff)
  );

  always_comb begin
    init_term = 1'b0;
    for (int k = 0; k < NUM_CT; k++)
      if (cfg_init_sel_i == CT_W'(k)) init_term = ct_i[k];
  end
  assign init_act = cfg_init_en_i & init_term;

  mc_reg u_reg (
    .clk_i(clk_eff), .rst_ni(rst_ni), .init_i(init_act),
    .init_val_i(cfg_init_preset_i), .tmode_i(cfg_tmode_i),
    .d_i(d_i), .q_o(q)
  );

  mc_oe_ctl #(.NUM_CT(NUM_CT), .CT_W(CT_W)) u_oe (
    .ct_i(ct_i), .mode_i(cfg_oe_mode_i), .sel_i(cfg_oe_sel_i),
    .gts_i(gts_i), .oe_o(oe_o)
  );

  assign pin_o     = cfg_out_reg_i ? q : d_i;
  assign fb_core_o = q;
  assign fb_pin_o  = oe_o ? pin_o : pad_i;
endmodule

// File: rtl/mc_macrocell_chk.sv
module mc_macrocell_chk #(
  parameter int NUM_GCLK = 2,
  parameter int NUM_CT   = 8,
  parameter int CT_W     = 3
) (
  input logic                rst_ni,
  input logic [NUM_GCLK-1:0] gclk_i,
  input logic [NUM_CT-1:0]   ct_i,
  input logic                d_i,
  input logic                gts_i,
  input logic                pad_i,
  input logic                cfg_init_en_i,
  input logic [CT_W-1:0]     cfg_init_sel_i,
  input logic                cfg_init_preset_i,
  input logic                cfg_out_reg_i,
  input logic [1:0]          cfg_oe_mode_i,
  input logic                pin_o,
  input logic                oe_o,
  input logic                fb_core_o,
  input logic                fb_pin_o
);
  // R8: global tri-state wins over every enable source
  a_r8_gts_forces_off: assert property (@(posedge gclk_i[0]) disable iff (!rst_ni)
    gts_i |-> !oe_o);

  // R7: constant-off mode never enables
  a_r7_const_off: assert property (@(posedge gclk_i[0]) disable iff (!rst_ni)
    (cfg_oe_mode_i == 2'd0) |-> !oe_o);

  // R7: constant-on mode enables whenever tri-state is released
  a_r7_const_on: assert property (@(posedge gclk_i[0]) disable iff (!rst_ni)
    (cfg_oe_mode_i == 2'd1 && !gts_i) |-> oe_o);

  // R6: combinational output follows the array input
  a_r6_comb_path: assert property (@(posedge gclk_i[0]) disable iff (!rst_ni)
    !cfg_out_reg_i |-> (pin_o == d_i));

  // R6, R9: registered output matches the core feedback
  a_r6_reg_path: assert property (@(posedge gclk_i[0]) disable iff (!rst_ni)
    cfg_out_reg_i |-> (pin_o == fb_core_o));

  // R10: undriven pin reflects the external level
  a_r10_fb_pad: assert property (@(posedge gclk_i[0]) disable iff (!rst_ni)
    !oe_o |-> (fb_pin_o == pad_i));

  // R5: held init term pins the register to the configured level
  a_r5_init_hold: assert property (@(posedge gclk_i[0]) disable iff (!rst_ni)
    (cfg_init_en_i && ct_i[cfg_init_sel_i]) |-> (fb_core_o == cfg_init_preset_i));
endmodule

bind mc_macrocell mc_macrocell_chk #(
  .NUM_GCLK(NUM_GCLK), .NUM_CT(NUM_CT), .CT_W(CT_W)
) u_chk (
  .rst_ni(rst_ni), .gclk_i(gclk_i), .ct_i(ct_i), .d_i(d_i), .gts_i(gts_i),
  .pad_i(pad_i), .cfg_init_en_i(cfg_init_en_i), .cfg_init_sel_i(cfg_init_sel_i),
  .cfg_init_preset_i(cfg_init_preset_i), .cfg_out_reg_i(cfg_out_reg_i),
  .cfg_oe_mode_i(cfg_oe_mode_i), .pin_o(pin_o), .oe_o(oe_o),
  .fb_core_o(fb_core_o), .fb_pin_o(fb_pin_o)
);

// File: tb/mc_macrocell_tb_top.sv
module mc_macrocell_tb_top;
  localparam int NG = 2;
  localparam int NC = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_ni = 1'b0;
  logic [NG-1:0] gclk = '0;
  logic [NC-1:0] ct = '0;
  logic          d = 1'b0, gts = 1'b0, pad = 1'b0;
  logic          tmode = 1'b0, cinv = 1'b0, ien = 1'b0, ipre = 1'b0, oreg = 1'b0;
  logic [3:0]    csel = '0;
  logic [2:0]    isel = '0, osel = '0;
  logic [1:0]    omode = '0;
  logic          pin, oe, fbc, fbp;

  mc_macrocell #(.NUM_GCLK(NG), .NUM_CT(NC)) dut_i (
    .rst_ni(rst_ni), .gclk_i(gclk), .ct_i(ct), .d_i(d), .gts_i(gts), .pad_i(pad),
    .cfg_tmode_i(tmode), .cfg_clk_sel_i(csel), .cfg_clk_inv_i(cinv),
    .cfg_init_en_i(ien), .cfg_init_sel_i(isel), .cfg_init_preset_i(ipre),
    .cfg_out_reg_i(oreg), .cfg_oe_mode_i(omode), .cfg_oe_sel_i(osel),
    .pin_o(pin), .oe_o(oe), .fb_core_o(fbc), .fb_pin_o(fbp)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    mq = 1'b0;   // reference register state
  string tag;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog expired act=%0d exp<=100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string t, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0b exp=%0b at %0t", t, act, exp, $time);
    end
  endtask

  function automatic bit src_of(input logic [3:0] s, input logic [NG-1:0] g,
                                input logic [NC-1:0] c);
    if (s < NG) return g[s];
    return c[s - NG];
  endfunction

  task automatic compare_all();
    bit term, oe_e, pin_e;
    term  = ct[osel];
    oe_e  = (omode == 2'd1) ? 1'b1 : (omode == 2'd2) ? term :
            (omode == 2'd3) ? !term : 1'b0;
    if (gts) oe_e = 1'b0;                     // R8
    pin_e = oreg ? mq : d;                    // R6
    chk({tag, " R9 fb_core_o"}, fbc, mq);
    chk("R6 pin_o", pin, pin_e);
    chk("R7 R8 oe_o", oe, oe_e);
    chk("R10 fb_pin_o", fbp, oe_e ? pin_e : pad);
  endtask

  // Configuration is loaded under reset; R11 reset state checked here.
  task automatic load_cfg(input string t, input bit tm, input logic [3:0] cs,
                          input bit ci, input bit ie, input logic [2:0] is,
                          input bit ip, input bit orr, input logic [1:0] om,
                          input logic [2:0] os);
    @(posedge clk); #1;
    rst_ni = 1'b0;
    gclk = '0; ct = '0; d = 1'b0; gts = 1'b0; pad = 1'b0;
    tag = t; tmode = tm; csel = cs; cinv = ci; ien = ie; isel = is;
    ipre = ip; oreg = orr; omode = om; osel = os;
    mq = 1'b0;
    @(negedge clk);
    chk("R11 reset clears register", fbc, 1'b0);
    compare_all();
    @(posedge clk); #1;
    rst_ni = 1'b1;
    @(negedge clk);
    compare_all();
  endtask

  // One step: data and non-clock terms first, then the clock source moves.
  task automatic step(input logic [NG-1:0] g, input logic [NC-1:0] c,
                      input bit dv, input bit gv, input bit pv);
    bit old_s, new_s, edge_hit, init_on;
    logic [NC-1:0] ca;
    @(posedge clk); #1;
    ca = c;
    if (csel >= NG) ca[csel - NG] = ct[csel - NG];
    d = dv; gts = gv; pad = pv; ct = ca;
    init_on = ien && ca[isel];
    if (init_on) mq = ipre;                   // R5 asynchronous init
    #1;
    old_s = src_of(csel, gclk, ct);
    gclk = g; ct = c;
    new_s = src_of(csel, gclk, ct);
    edge_hit = cinv ? (old_s && !new_s) : (!old_s && new_s);  // R3, R4
    if (!init_on && edge_hit) mq = tmode ? (mq ^ dv) : dv;   // R1, R2
    @(negedge clk);
    compare_all();
  endtask

  task automatic run_random(input int n);
    for (int i = 0; i < n; i++) begin
      logic [NG-1:0] g;
      logic [NC-1:0] c;
      g = gclk ^ NG'($urandom);
      c = ct ^ NC'($urandom);
      if (ien) c[isel] = (($urandom % 8) == 0);
      step(g, c, 1'($urandom), (($urandom % 4) == 0), 1'($urandom));
    end
  endtask

  initial begin
    tag = "";
    // R1 R4: D register on gclk0 rising, always enabled
    load_cfg("R1 R4", 0, 4'd0, 0, 0, 3'd0, 0, 1, 2'd1, 3'd0);
    step(2'b00, '0, 1, 0, 0);
    step(2'b01, '0, 1, 0, 0);   // rising edge captures 1
    step(2'b00, '0, 0, 0, 0);   // falling edge ignored
    step(2'b10, '0, 0, 0, 0);   // gclk1 edge ignored (R4)
    step(2'b11, '0, 0, 0, 0);   // gclk0 rise captures 0
    run_random(150);
    // R2 R5: T register on gclk1 rising, reset via ct[5], OE from ct[2]
    load_cfg("R2 R5", 1, 4'd1, 0, 1, 3'd5, 0, 1, 2'd2, 3'd2);
    step(2'b10, '0, 1, 0, 0);   // toggle to 1
    step(2'b00, '0, 1, 0, 0);
    step(2'b10, '0, 0, 0, 0);   // hold
    step(2'b10, 8'h20, 0, 0, 1); // reset term forces 0
    run_random(150);
    // R3 R5: D register on gclk0 falling, preset via ct[6], OE = !ct[3]
    load_cfg("R3 R5", 0, 4'd0, 1, 1, 3'd6, 1, 1, 2'd3, 3'd3);
    step(2'b01, '0, 1, 0, 1);   // rising ignored
    step(2'b00, '0, 1, 0, 1);   // falling captures
    step(2'b00, 8'h40, 0, 0, 0); // preset
    run_random(150);
    // R4 R6 R7: T register clocked by ct[1] falling, comb output, OE off
    load_cfg("R2 R3 R4 R6", 1, 4'd3, 1, 1, 3'd4, 1, 0, 2'd0, 3'd0);
    run_random(150);
    // R4 R6: D register clocked by ct[0] rising, comb out, reset via ct[7]
    load_cfg("R1 R4 R6", 0, 4'd2, 0, 1, 3'd7, 0, 0, 2'd1, 3'd0);
    run_random(150);
    // R2 R3 R7: T register on gclk1 falling, OE = ct[1]
    load_cfg("R2 R3 R7", 1, 4'd1, 1, 0, 3'd0, 0, 1, 2'd2, 3'd1);
    run_random(150);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule